// File: doc/BRIEF.md
# Direction-Aware Blit Start Address Generator

This block turns the geometry of a rectangular screen-to-screen copy into the values a copy engine needs before it can begin. It takes pixel coordinates for the source and destination corners, the rectangle size, the bytes per pixel, the display pitch and one walk-direction flag per axis. It returns two byte start addresses, a two-bit direction code, a source row-stride value and a one-cycle start pulse. When source and destination overlap, the caller picks the walk direction on each axis so that no pixel is overwritten before it is read. For a decreasing walk, the start address is moved to the far edge of the rectangle.

A request is taken only while the block is idle. It then passes through a four-state machine. IDLE waits for `req` and captures every operand (IDLE to SCALE on `req`). SCALE converts x positions, the width and the pitch to bytes, and selects the start row and the start byte offset for each side (SCALE to ADDR, unconditional). ADDR forms row times line width plus offset, and registers the addresses, the direction code and the stride value (ADDR to FIRE, unconditional). FIRE makes the start strobe one cycle later (FIRE to IDLE, unconditional). The strobe stands for the write of the destination address that launches the copy.

Top module: `blit_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request completes, `busy`, `start`, `src_addr`, `dst_addr`, `dir_code` and `src_yoff` are all zero.
- R2: `bpp_sel` encodes bytes per pixel B as 0→1, 1→2, 2→3, 3→4. The line width is `pitch`·B, and `src_yoff` becomes line width − 1.
- R3: `dir_code` bit 0 is set when `x_dec` was set (right-to-left), and bit 1 is set when `y_dec` was set (bottom-to-top).
- R4: With both flags clear, each start address is y·(`pitch`·B) + x·B, using that side's own x and y.
- R5: With `y_dec` set, the start row of both sides is y + `height` − 1 instead of y.
- R6: With `x_dec` set, the start byte in the row is x·B + `width`·B − 1, which is the last byte of the last pixel. Without it, the start byte is x·B.
- R7: A request sampled at clock edge k while idle holds `busy` high from edge k to edge k+3. The new outputs appear at edge k+2. `start` is high for exactly the one cycle that follows edge k+3.
- R8: `req` is ignored while `busy` is high. Between completed requests, the four result outputs hold their values.
- R9: All address arithmetic is unsigned and modulo 2^24. A start address that exceeds 24 bits wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request a new address computation |
| src_x | input | 12 | Source left pixel column |
| src_y | input | 12 | Source top pixel row |
| dst_x | input | 12 | Destination left pixel column |
| dst_y | input | 12 | Destination top pixel row |
| width | input | 12 | Rectangle width in pixels |
| height | input | 12 | Rectangle height in rows |
| x_dec | input | 1 | Walk x right-to-left |
| y_dec | input | 1 | Walk y bottom-to-top |
| bpp_sel | input | 2 | Bytes per pixel code (B = code + 1) |
| pitch | input | 12 | Display pitch in pixels |
| busy | output | 1 | A request is in progress |
| src_addr | output | 24 | Source start byte address |
| dst_addr | output | 24 | Destination start byte address |
| dir_code | output | 2 | Walk direction code |
| src_yoff | output | 24 | Line width in bytes minus one |
| start | output | 1 | One-cycle launch strobe |

## Verification
All four combinations of the direction flags are applied with differing source and destination corners. This shows whether each flag moves only its own axis and whether each side uses its own coordinates. Every byte-per-pixel code is applied, and the three-byte case is combined with a decreasing x walk, so an error in the x + 2x multiply or in the last-byte adjustment shows up. A one-pixel rectangle shows whether the end-point correction is off by one. A far corner with the largest pitch forces 24-bit wrap. A `req` held high across several requests, with operands that change while the block is busy, shows whether a request is accepted only when the block is idle and whether back-to-back requests come out in the right order.

// File: rtl/blit_pkg.sv
package blit_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_SCALE,
        S_ADDR,
        S_FIRE
    } blit_state_e;

    localparam int NUM_LANES = 4;
    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/blit_bpp_scale.sv
module blit_bpp_scale #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] value,
    input  logic [1:0]    bpp_sel,
    output logic [AW-1:0] scaled
);
    // Scale a pixel count to bytes; three bytes uses value + 2*value
    always_comb begin
        unique case (bpp_sel)
            2'd0:    scaled = value;
            2'd1:    scaled = value << 1;
            2'd2:    scaled = value + (value << 1);
            default: scaled = value << 2;
        endcase
    end
endmodule

// File: rtl/blit_end_adjust.sv
module blit_end_adjust #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] x_bytes,
    input  logic [AW-1:0] w_bytes,
    input  logic          x_dec,
    input  logic [AW-1:0] y_row,
    input  logic [AW-1:0] h_rows,
    input  logic          y_dec,
    output logic [AW-1:0] start_row,
    output logic [AW-1:0] start_byte
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    // A decreasing walk begins at the far edge of its axis
    always_comb begin
        start_row  = y_dec ? (y_row + h_rows - ONE) : y_row;
        start_byte = x_dec ? (x_bytes + w_bytes - ONE) : x_bytes;
    end
endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
    import blit_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [CW-1:0] src_x,
    input  logic [CW-1:0] src_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic          x_dec,
    input  logic          y_dec,
    input  logic [1:0]    bpp_sel,
    input  logic [CW-1:0] pitch,
    output logic          busy,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [1:0]    dir_code,
    output logic [AW-1:0] src_yoff,
    output logic          start
);
    localparam int            PADW = AW - CW;
    localparam logic [AW-1:0] ONE  = {{(AW-1){1'b0}}, 1'b1};

    blit_state_e state_q, state_d;

    // captured request operands
    logic [CW-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q, p_q;
    logic          xd_q, yd_q;
    logic [1:0]    b_q;

    // byte-scaling lanes: 0 src x, 1 dst x, 2 width, 3 pitch
    logic [AW-1:0] lane_in  [NUM_LANES];
    logic [AW-1:0] lane_out [NUM_LANES];

    assign lane_in[0] = {{PADW{1'b0}}, sx_q};
    assign lane_in[1] = {{PADW{1'b0}}, dx_q};
    assign lane_in[2] = {{PADW{1'b0}}, w_q};
    assign lane_in[3] = {{PADW{1'b0}}, p_q};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        blit_bpp_scale #(.AW(AW)) u_scale (
            .value  (lane_in[g]),
            .bpp_sel(b_q),
            .scaled (lane_out[g])
        );
    end

    // per-side end-point selection: 0 source, 1 destination
    logic [AW-1:0] side_y   [NUM_SIDES];
    logic [AW-1:0] row_c    [NUM_SIDES];
    logic [AW-1:0] off_c    [NUM_SIDES];
    logic [AW-1:0] row_q    [NUM_SIDES];
    logic [AW-1:0] off_q    [NUM_SIDES];
    logic [2*AW-1:0] prod_c [NUM_SIDES];
    logic [AW-1:0] addr_c   [NUM_SIDES];
    logic [AW-1:0] lw_q;
    logic [AW-1:0] h_ext;

    assign side_y[0] = {{PADW{1'b0}}, sy_q};
    assign side_y[1] = {{PADW{1'b0}}, dy_q};
    assign h_ext     = {{PADW{1'b0}}, h_q};

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        blit_end_adjust #(.AW(AW)) u_adj (
            .x_bytes   (lane_out[s]),
            .w_bytes   (lane_out[2]),
            .x_dec     (xd_q),
            .y_row     (side_y[s]),
            .h_rows    (h_ext),
            .y_dec     (yd_q),
            .start_row (row_c[s]),
            .start_byte(off_c[s])
        );
        assign prod_c[s] = row_q[s] * lw_q;
        assign addr_c[s] = prod_c[s][AW-1:0] + off_q[s];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req) state_d = S_SCALE;
            S_SCALE: state_d = S_ADDR;
            S_ADDR:  state_d = S_FIRE;
            S_FIRE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign busy = (state_q != S_IDLE);

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sx_q <= '0; sy_q <= '0; dx_q <= '0; dy_q <= '0;
            w_q  <= '0; h_q  <= '0; p_q  <= '0;
            xd_q <= 1'b0; yd_q <= 1'b0; b_q <= '0;
            for (int i = 0; i < NUM_SIDES; i++) begin
                row_q[i] <= '0;
                off_q[i] <= '0;
            end
            lw_q     <= '0;
            src_addr <= '0;
            dst_addr <= '0;
            dir_code <= '0;
            src_yoff <= '0;
            start    <= 1'b0;
        end else begin
            start <= (state_q == S_FIRE);
            unique case (state_q)
                S_IDLE: begin
                    if (req) begin
                        sx_q <= src_x; sy_q <= src_y;
                        dx_q <= dst_x; dy_q <= dst_y;
                        w_q  <= width; h_q  <= height;
                        p_q  <= pitch; b_q  <= bpp_sel;
                        xd_q <= x_dec; yd_q <= y_dec;
                    end
                end
                S_SCALE: begin
                    for (int i = 0; i < NUM_SIDES; i++) begin
                        row_q[i] <= row_c[i];
                        off_q[i] <= off_c[i];
                    end
                    lw_q <= lane_out[3];
                end
                S_ADDR: begin
                    src_addr <= addr_c[0];
                    dst_addr <= addr_c[1];
                    dir_code <= {yd_q, xd_q};
                    src_yoff <= lw_q - ONE;
                end
                S_FIRE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R7: strobe lasts a single cycle
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R7: strobe only follows the launch state
    a_r7_strobe_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(state_q == S_FIRE));

    // R8: an idle request makes the block busy on the next cycle
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> busy);

    // R8: results hold while idle
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(src_addr) && $stable(dst_addr) && $stable(dir_code)));

    // R3: direction code reflects the captured flags at launch
    a_r3_dir_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (dir_code == {yd_q, xd_q}));

    // R2: stride value is one below the scaled pitch at launch
    a_r2_yoff_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ((src_yoff + ONE) == lw_q));
endmodule

// File: tb/test_blit_addr_gen.sv
`timescale 1ns/1ps
module test_blit_addr_gen;
    localparam int AW = 24;
    localparam int CW = 12;
    localparam longint MODV = 64'h1000000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req;
    logic [CW-1:0] src_x, src_y, dst_x, dst_y, width, height, pitch;
    logic          x_dec, y_dec;
    logic [1:0]    bpp_sel;
    logic          busy, start;
    logic [AW-1:0] src_addr, dst_addr, src_yoff;
    logic [1:0]    dir_code;

    always #2.5 clk = ~clk;

    blit_addr_gen #(.AW(AW), .CW(CW)) i_blit_addr_gen (
        .clk(clk), .rst_n(rst_n), .req(req),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .width(width), .height(height), .x_dec(x_dec), .y_dec(y_dec),
        .bpp_sel(bpp_sel), .pitch(pitch), .busy(busy),
        .src_addr(src_addr), .dst_addr(dst_addr), .dir_code(dir_code),
        .src_yoff(src_yoff), .start(start)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    int  cyc    = 0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int     m_cnt;
    bit     m_start;
    longint m_src, m_dst, m_yoff;
    longint p_src, p_dst, p_yoff;
    int     m_dir, p_dir;
    string  m_tag, p_tag;
    longint b, lw, rs, rd, os, od, fs, fd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_start = 0;
            m_src = 0; m_dst = 0; m_yoff = 0; m_dir = 0;
            m_tag = "R4";
        end else begin
            m_start = 0;
            case (m_cnt)
                0: if (req) begin
                    b  = longint'(bpp_sel) + 1;
                    lw = longint'(pitch) * b;
                    rs = y_dec ? longint'(src_y) + longint'(height) - 1 : longint'(src_y);
                    rd = y_dec ? longint'(dst_y) + longint'(height) - 1 : longint'(dst_y);
                    os = longint'(src_x) * b;
                    od = longint'(dst_x) * b;
                    if (x_dec) begin
                        os = os + longint'(width) * b - 1;
                        od = od + longint'(width) * b - 1;
                    end
                    fs = rs * lw + os;
                    fd = rd * lw + od;
                    p_src  = fs % MODV;
                    p_dst  = fd % MODV;
                    p_yoff = lw - 1;
                    p_dir  = {30'd0, y_dec, x_dec};
                    if (fs >= MODV || fd >= MODV) p_tag = "R9";
                    else if (x_dec)               p_tag = "R6";
                    else if (y_dec)               p_tag = "R5";
                    else                          p_tag = "R4";
                    m_cnt = 1;
                end
                1: m_cnt = 2;
                2: begin
                    m_src = p_src; m_dst = p_dst; m_yoff = p_yoff;
                    m_dir = p_dir; m_tag = p_tag;
                    m_cnt = 3;
                end
                default: begin
                    m_start = 1;
                    m_cnt = 0;
                end
            endcase
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            string ta;
            ta = !rst_n ? "R1" : (m_start ? m_tag : "R8");
            chk(busy === (m_cnt != 0), !rst_n ? "R1 busy" : "R7 busy", longint'(busy), longint'(m_cnt != 0));
            chk(start === m_start, !rst_n ? "R1 start" : "R7 start", longint'(start), longint'(m_start));
            chk(longint'(src_addr) == m_src, {ta, " src_addr"}, longint'(src_addr), m_src);
            chk(longint'(dst_addr) == m_dst, {ta, " dst_addr"}, longint'(dst_addr), m_dst);
            chk(int'(dir_code) == m_dir, !rst_n ? "R1 dir" : "R3 dir_code", longint'(dir_code), longint'(m_dir));
            chk(longint'(src_yoff) == m_yoff % MODV, !rst_n ? "R1 yoff" : "R2 src_yoff", longint'(src_yoff), m_yoff % MODV);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic drive(int sx, int sy, int dx, int dy, int w, int h,
                         bit xd, bit yd, int bs, int p);
        src_x = CW'(sx); src_y = CW'(sy); dst_x = CW'(dx); dst_y = CW'(dy);
        width = CW'(w); height = CW'(h); x_dec = xd; y_dec = yd;
        bpp_sel = 2'(bs); pitch = CW'(p);
    endtask

    task automatic issue(int sx, int sy, int dx, int dy, int w, int h,
                         bit xd, bit yd, int bs, int p);
        @(negedge clk);
        drive(sx, sy, dx, dy, w, h, xd, yd, bs, p);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        req   = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset with cleared results
        chk(src_addr == '0 && dst_addr == '0 && src_yoff == '0 && dir_code == '0,
            "R1 reset outputs", longint'(src_addr), 0);

        issue(3, 2, 10, 5, 4, 3, 1'b0, 1'b0, 0, 640);   // R4 B=1
        issue(3, 2, 10, 5, 4, 3, 1'b1, 1'b0, 1, 640);   // R6 B=2
        issue(7, 9, 1, 20, 6, 5, 1'b0, 1'b1, 2, 320);   // R5 B=3
        issue(7, 9, 1, 20, 5, 5, 1'b1, 1'b1, 2, 333);   // R6 B=3 last byte
        issue(12, 4, 30, 8, 9, 7, 1'b1, 1'b1, 3, 800);  // R2 B=4
        issue(0, 0, 5, 5, 1, 1, 1'b1, 1'b1, 1, 100);    // R6 one pixel
        issue(0, 0, 0, 0, 1, 1, 1'b0, 1'b0, 0, 1);      // R4 origin
        issue(4000, 4000, 3900, 4090, 50, 5, 1'b1, 1'b1, 3, 4095); // R9 wrap

        // R8: req held high, operands changed while busy
        @(negedge clk);
        drive(11, 12, 13, 14, 2, 2, 1'b0, 1'b1, 1, 200);
        req = 1'b1;
        @(negedge clk);
        drive(99, 98, 97, 96, 3, 3, 1'b1, 1'b0, 3, 50);
        repeat (5) @(negedge clk);
        drive(21, 22, 23, 24, 4, 4, 1'b1, 1'b1, 0, 64);
        repeat (4) @(negedge clk);
        req = 1'b0;
        repeat (8) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule